// File: doc/BRIEF.md
# Buffered SPI Slave Transmitter

This block is an SPI slave that runs on the system clock. It oversamples the serial clock, the active-low select and the MOSI line through synchronisers, and it drives MISO from an 8-bit shift register. A single-entry transmit holding buffer sits behind the shift register. The host fills that buffer through a one-cycle write strobe. A write that arrives while the buffer is occupied is thrown away, and the buffer keeps the byte it already holds.

A configuration input selects how the first transfer starts:

- With the input low, the first transfer sends whatever the shift register already contains, as a dummy byte. The buffered byte moves into the shift register only after that transfer ends.
- With the input high, a write made while the select is inactive is moved into the shift register on the following clock. The next write then lands in the buffer.

Three status flags report progress: buffer-empty, receive-complete and transfer-complete. They follow a fixed one-cycle order. The last received byte is also presented on a port.

Top module: `spi_buf_slave`

## Requirements
- R1: After reset, buffer-empty is 1, receive-complete and transfer-complete are 0, `miso_oe` is 0 and `rx_data` is 0x00.
- R2: SPI mode 0 with the most significant bit first. MISO presents the next bit before each rising SCK edge and changes after the falling edge. MOSI is sampled on the rising edge, and `rx_data` shows the 8 sampled bits with the first bit in bit 7.
- R3: With `cfg_wait_rx` = 0, a write never reaches the shift register directly. The first transfer after reset sends the shift register's current content (0x00 after reset), and the written byte is sent in the following transfer.
- R4: With `cfg_wait_rx` = 1, a write accepted while the select is high and the shift register holds no unsent data is moved into the shift register one cycle later and is sent in the next transfer. A further write is held in the buffer and is sent in the transfer after that.
- R5: A write that arrives while buffer-empty is 0 is discarded, and the byte already in the buffer is the one sent later.
- R6: Buffer-empty falls in the cycle after an accepted write. It rises at the end of a transfer when the buffered byte is copied into the shift register.
- R7: Receive-complete rises exactly one clock after the end-of-transfer rise of buffer-empty (one clock after the end of the transfer in general). `rx_data` is updated at the same moment.
- R8: Transfer-complete rises exactly one clock after receive-complete, and only if the buffer was empty at the end of the transfer, so that no byte is left to send.
- R9: A rise of the select line before the eighth SCK rising edge abandons the byte without setting any flag, and the next transfer starts again from bit 7.
- R10: `clr_rxc` clears receive-complete and `clr_txc` clears transfer-complete, each independently. A set event in the same cycle wins over the clear.
- R11: `miso_oe` is 0 while the select is high and 1 while it is low, after the synchroniser delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wait_rx | input | 1 | Start behaviour: 0 sends a dummy byte first, 1 preloads while idle |
| wr_en | input | 1 | Host write strobe for the transmit buffer |
| wr_data | input | 8 | Host write data |
| clr_rxc | input | 1 | Write-one-to-clear strobe for receive-complete |
| clr_txc | input | 1 | Write-one-to-clear strobe for transfer-complete |
| sck_i | input | 1 | Serial clock from the master (asynchronous) |
| ss_n_i | input | 1 | Active-low slave select (asynchronous) |
| mosi_i | input | 1 | Serial data from the master (asynchronous) |
| miso_o | output | 1 | Serial data to the master |
| miso_oe | output | 1 | Output enable for MISO |
| flag_dre | output | 1 | Transmit buffer empty |
| flag_rxc | output | 1 | Receive complete |
| flag_txc | output | 1 | Transfer complete with nothing pending |
| rx_data | output | 8 | Last received byte |

## Verification
The hardest state to reach is the one where the buffer is full, the shift register is loaded and a transfer is in flight. Only in that state are dropped writes, the pending-data gating of transfer-complete and the exact spacing of the three flags all visible at once. The bench reaches it after reset with the dummy-first start: it writes one byte, then shows with a second write that the buffer rejects it, and runs three back-to-back transfers. Between the transfers it makes more writes, some into a full buffer and some into an empty one. Around the last SCK rising edge of each byte, the bench records clock by clock the cycle in which each flag first goes high.

// File: rtl/spi_buf_pkg.sv
// Shared types for the buffered SPI slave.
package spi_buf_pkg;
    // Synchronised pin events delivered by the front end to the datapath.
    typedef struct packed {
        logic sck_rise;
        logic sck_fall;
        logic ss_idle;
        logic mosi;
    } spi_pins_t;
endpackage

// File: rtl/spi_buf_sync.sv
// Multi-stage synchroniser for a vector of asynchronous inputs.
// Assumes each bit is independent; RESET_VAL gives each bit's idle level.
module spi_buf_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // First stage captures the raw input.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= RESET_VAL;
                else        stage_q[s] <= async_i;
            end
        end else begin : g_next
            // Later stages resolve metastability.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= RESET_VAL;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/spi_buf_frontend.sv
// Synchronises SCK, select and MOSI and turns SCK into single-cycle
// edge events. Assumes SCK is slower than a quarter of the system clock.
module spi_buf_frontend
    import spi_buf_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sck_i,
    input  logic      ss_n_i,
    input  logic      mosi_i,
    output spi_pins_t pins_o
);
    logic [2:0] raw;
    logic [2:0] synced;
    logic       sck_prev_q;

    assign raw = {sck_i, ss_n_i, mosi_i};

    spi_buf_sync #(
        .WIDTH    (3),
        .STAGES   (SYNC_STAGES),
        .RESET_VAL(3'b010)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(raw),
        .sync_o (synced)
    );

    // Remember the previous synchronised SCK level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_prev_q <= 1'b0;
        else        sck_prev_q <= synced[2];
    end

    // Build the event bundle.
    always_comb begin
        pins_o.sck_rise = synced[2] & ~sck_prev_q;
        pins_o.sck_fall = ~synced[2] & sck_prev_q;
        pins_o.ss_idle  = synced[1];
        pins_o.mosi     = synced[0];
    end
endmodule

// File: rtl/spi_buf_shifter.sv
// Bit counter plus transmit and receive shift registers, SPI mode 0,
// MSB first. A load request takes priority over shifting; loads only
// occur at byte end or while idle, so they never meet a falling edge.
module spi_buf_shifter
    import spi_buf_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  spi_pins_t         pins,
    input  logic              load_en,
    input  logic [DATA_W-1:0] load_data,
    output logic              miso,
    output logic              byte_done,
    output logic [DATA_W-1:0] rx_byte
);
    localparam int unsigned CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] tx_q;
    logic [DATA_W-1:0] rx_q;
    logic              active;

    assign active    = ~pins.ss_idle;
    assign byte_done = active & pins.sck_rise & (cnt_q == LAST);

    // Count rising edges; an idle select abandons any partial byte.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (!active)       cnt_q <= '0;
        else if (pins.sck_rise) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    // Transmit register: load, or shift left after each non-final bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tx_q <= '0;
        else if (load_en)
            tx_q <= load_data;
        else if (active && pins.sck_fall && cnt_q != '0)
            tx_q <= {tx_q[DATA_W-2:0], 1'b0};
    end

    // Receive register: sample MOSI on every rising edge while selected.
    always_ff @(posedge clk) begin
        if (!rst_n)                       rx_q <= '0;
        else if (active && pins.sck_rise) rx_q <= {rx_q[DATA_W-2:0], pins.mosi};
    end

    assign miso    = tx_q[DATA_W-1];
    assign rx_byte = rx_q;
endmodule

// File: rtl/spi_buf_txhold.sv
// Single-entry transmit holding buffer. Writes into a full buffer are
// dropped. Decides when the buffer is copied into the shift register:
// at each byte end, or while idle when the preload start is selected.
module spi_buf_txhold #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wait_rx,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ss_idle,
    input  logic              byte_done,
    output logic              load_en,
    output logic [DATA_W-1:0] hold_q,
    output logic              full_q,
    output logic              loaded_q,
    output logic              done_clean
);
    logic accept;
    logic preload;
    logic copy_at_end;

    assign accept      = wr_en & ~full_q;
    assign preload     = cfg_wait_rx & ss_idle & full_q & ~loaded_q;
    assign copy_at_end = byte_done & full_q;
    assign load_en     = preload | copy_at_end;
    assign done_clean  = byte_done & ~full_q;

    // Store accepted write data.
    always_ff @(posedge clk) begin
        if (!rst_n)      hold_q <= '0;
        else if (accept) hold_q <= wr_data;
    end

    // Occupancy: set by an accepted write, cleared by a copy-out.
    always_ff @(posedge clk) begin
        if (!rst_n)       full_q <= 1'b0;
        else if (accept)  full_q <= 1'b1;
        else if (load_en) full_q <= 1'b0;
    end

    // Track whether the shift register holds user data not yet sent.
    always_ff @(posedge clk) begin
        if (!rst_n)         loaded_q <= 1'b0;
        else if (load_en)   loaded_q <= 1'b1;
        else if (byte_done) loaded_q <= 1'b0;
    end
endmodule

// File: rtl/spi_buf_flags.sv
// Receive-complete and transfer-complete sequencing with
// write-one-to-clear strobes, plus the received-byte register.
module spi_buf_flags #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_done,
    input  logic              done_clean,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              clr_rxc,
    input  logic              clr_txc,
    output logic              rxc_q,
    output logic              txc_q,
    output logic [DATA_W-1:0] rx_data_q
);
    logic done_d1_q;
    logic done_d2_q;
    logic clean_d1_q;
    logic clean_d2_q;

    // Two-stage delay line from byte end to the flag set points.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_d1_q  <= 1'b0;
            done_d2_q  <= 1'b0;
            clean_d1_q <= 1'b0;
            clean_d2_q <= 1'b0;
        end else begin
            done_d1_q  <= byte_done;
            done_d2_q  <= done_d1_q;
            clean_d1_q <= done_clean;
            clean_d2_q <= clean_d1_q;
        end
    end

    // Receive-complete: set one cycle after byte end, set beats clear.
    always_ff @(posedge clk) begin
        if (!rst_n)         rxc_q <= 1'b0;
        else if (done_d1_q) rxc_q <= 1'b1;
        else if (clr_rxc)   rxc_q <= 1'b0;
    end

    // Capture the received byte together with receive-complete.
    always_ff @(posedge clk) begin
        if (!rst_n)         rx_data_q <= '0;
        else if (done_d1_q) rx_data_q <= rx_byte;
    end

    // Transfer-complete: one cycle after receive-complete if nothing pends.
    always_ff @(posedge clk) begin
        if (!rst_n)                        txc_q <= 1'b0;
        else if (done_d2_q && clean_d2_q)  txc_q <= 1'b1;
        else if (clr_txc)                  txc_q <= 1'b0;
    end
endmodule

// File: rtl/spi_buf_slave.sv
// Top level of the buffered SPI slave transmit path. Connects the pin
// front end, the shifter, the holding buffer and the flag sequencer.
// Assumes SCK runs well below a quarter of the system clock.
module spi_buf_slave
    import spi_buf_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wait_rx,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              clr_rxc,
    input  logic              clr_txc,
    input  logic              sck_i,
    input  logic              ss_n_i,
    input  logic              mosi_i,
    output logic              miso_o,
    output logic              miso_oe,
    output logic              flag_dre,
    output logic              flag_rxc,
    output logic              flag_txc,
    output logic [DATA_W-1:0] rx_data
);
    spi_pins_t         pins;
    logic              ss_idle;
    logic              byte_done;
    logic              load_en;
    logic [DATA_W-1:0] hold_q;
    logic              full_q;
    logic              loaded_q;
    logic              done_clean;
    logic [DATA_W-1:0] rx_byte;

    spi_buf_frontend #(.SYNC_STAGES(SYNC_STAGES)) u_front (
        .clk   (clk),
        .rst_n (rst_n),
        .sck_i (sck_i),
        .ss_n_i(ss_n_i),
        .mosi_i(mosi_i),
        .pins_o(pins)
    );

    assign ss_idle = pins.ss_idle;

    spi_buf_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .pins     (pins),
        .load_en  (load_en),
        .load_data(hold_q),
        .miso     (miso_o),
        .byte_done(byte_done),
        .rx_byte  (rx_byte)
    );

    spi_buf_txhold #(.DATA_W(DATA_W)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wait_rx(cfg_wait_rx),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .ss_idle    (ss_idle),
        .byte_done  (byte_done),
        .load_en    (load_en),
        .hold_q     (hold_q),
        .full_q     (full_q),
        .loaded_q   (loaded_q),
        .done_clean (done_clean)
    );

    spi_buf_flags #(.DATA_W(DATA_W)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_done (byte_done),
        .done_clean(done_clean),
        .rx_byte   (rx_byte),
        .clr_rxc   (clr_rxc),
        .clr_txc   (clr_txc),
        .rxc_q     (flag_rxc),
        .txc_q     (flag_txc),
        .rx_data_q (rx_data)
    );

    assign flag_dre = ~full_q;
    assign miso_oe  = ~ss_idle;
endmodule

// File: rtl/spi_buf_checker.sv
// Temporal checks on the buffered SPI slave, bound into the top module.
module spi_buf_checker #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wait_rx,
    input logic              wr_en,
    input logic              flag_dre,
    input logic              flag_rxc,
    input logic              flag_txc,
    input logic              byte_done,
    input logic              ss_idle,
    input logic              loaded_q,
    input logic [DATA_W-1:0] hold_q
);
    AST_DROP_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !flag_dre) |=> (hold_q == $past(hold_q)));              // R5
    AST_DRE_FALLS_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && flag_dre) |=> !flag_dre);                               // R6
    AST_RXC_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_rxc) |-> ($past(flag_dre) && $past(byte_done, 2)));    // R7
    AST_TXC_AFTER_RXC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_txc) |-> $past(flag_rxc));                             // R8
    AST_PRELOAD_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(loaded_q) && !$past(byte_done)) |-> $past(ss_idle && cfg_wait_rx)); // R4
endmodule

bind spi_buf_slave spi_buf_checker #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wait_rx(cfg_wait_rx),
    .wr_en      (wr_en),
    .flag_dre   (flag_dre),
    .flag_rxc   (flag_rxc),
    .flag_txc   (flag_txc),
    .byte_done  (byte_done),
    .ss_idle    (ss_idle),
    .loaded_q   (loaded_q),
    .hold_q     (hold_q)
);

// File: tb/spi_buf_slave_bench.sv
module spi_buf_slave_bench;
    localparam int HALF = 6;
    localparam int NVEC = 4;
    // Each entry: {byte the slave must send, byte the master sends}
    localparam logic [15:0] VEC [NVEC] = '{16'hA55A, 16'h0FF0, 16'h8001, 16'h3CC3};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wait_rx = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       clr_rxc = 1'b0;
    logic       clr_txc = 1'b0;
    logic       sck_i = 1'b0;
    logic       ss_n_i = 1'b1;
    logic       mosi_i = 1'b0;
    logic       miso_o, miso_oe, flag_dre, flag_rxc, flag_txc;
    logic [7:0] rx_data;

    int checks = 0;
    int fails = 0;
    int t_dre, t_rxc, t_txc;
    logic [7:0] got;

    always #4 clk = ~clk;

    spi_buf_slave u_spi_buf_slave (
        .clk(clk), .rst_n(rst_n), .cfg_wait_rx(cfg_wait_rx),
        .wr_en(wr_en), .wr_data(wr_data), .clr_rxc(clr_rxc), .clr_txc(clr_txc),
        .sck_i(sck_i), .ss_n_i(ss_n_i), .mosi_i(mosi_i),
        .miso_o(miso_o), .miso_oe(miso_oe), .flag_dre(flag_dre),
        .flag_rxc(flag_rxc), .flag_txc(flag_txc), .rx_data(rx_data)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic wait_mode);
        @(negedge clk);
        rst_n = 1'b0;
        cfg_wait_rx = wait_mode;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic host_write(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic clear_flags();
        @(negedge clk);
        clr_rxc = 1'b1;
        clr_txc = 1'b1;
        @(negedge clk);
        clr_rxc = 1'b0;
        clr_txc = 1'b0;
    endtask

    task automatic select(input logic on);
        @(negedge clk);
        ss_n_i = ~on;
        repeat (HALF) @(negedge clk);
    endtask

    // One byte in mode 0; records flag timing around the final rising edge.
    task automatic xfer(input logic [7:0] mo, output logic [7:0] mi);
        t_dre = -1; t_rxc = -1; t_txc = -1;
        for (int b = 7; b >= 0; b--) begin
            mosi_i = mo[b];
            repeat (HALF) @(negedge clk);
            mi[b] = miso_o;
            sck_i = 1'b1;
            if (b == 0) begin
                logic prev_dre;
                prev_dre = flag_dre;
                for (int c = 0; c < 2 * HALF; c++) begin
                    @(negedge clk);
                    if (t_dre < 0 && flag_dre && !prev_dre) t_dre = c;
                    if (t_rxc < 0 && flag_rxc) t_rxc = c;
                    if (t_txc < 0 && flag_txc) t_txc = c;
                    prev_dre = flag_dre;
                end
            end else begin
                repeat (HALF) @(negedge clk);
            end
            sck_i = 1'b0;
        end
        repeat (HALF) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        do_reset(1'b1);
        // R1 reset state
        check("R1 dre", flag_dre, 1);
        check("R1 rxc", flag_rxc, 0);
        check("R1 txc", flag_txc, 0);
        check("R1 oe", miso_oe, 0);
        check("R1 rx_data", rx_data, 0);

        // Table walk: preload start, loopback of each vector
        for (int i = 0; i < NVEC; i++) begin
            host_write(VEC[i][15:8]);
            repeat (3) @(negedge clk);
            check("R4 dre after preload", flag_dre, 1);
            select(1'b1);
            check("R11 oe selected", miso_oe, 1);
            xfer(VEC[i][7:0], got);
            select(1'b0);
            check("R11 oe idle", miso_oe, 0);
            check("R2 miso byte", got, VEC[i][15:8]);
            check("R2 rx_data", rx_data, VEC[i][7:0]);
            check("R7 rxc set", flag_rxc, 1);
            check("R8 txc set", flag_txc, 1);
            @(negedge clk); clr_rxc = 1'b1; @(negedge clk); clr_rxc = 1'b0;
            check("R10 rxc cleared", flag_rxc, 0);
            check("R10 txc kept", flag_txc, 1);
            @(negedge clk); clr_txc = 1'b1; @(negedge clk); clr_txc = 1'b0;
            check("R10 txc cleared", flag_txc, 0);
        end

        // R4: second write buffered, third dropped (R5)
        host_write(8'h43);
        repeat (3) @(negedge clk);
        host_write(8'h44);
        check("R6 dre low after write", flag_dre, 0);
        host_write(8'h45);
        select(1'b1);
        xfer(8'h11, got);
        check("R4 first sent", got, 8'h43);
        check("R8 txc held while pending", flag_txc, 0);
        clear_flags();
        xfer(8'h22, got);
        select(1'b0);
        check("R4 buffered sent R5 drop", got, 8'h44);
        check("R8 txc after drain", flag_txc, 1);
        clear_flags();

        // R9: abort mid-byte, then a clean byte realigned
        host_write(8'h96);
        select(1'b1);
        for (int k = 0; k < 3; k++) begin
            repeat (HALF) @(negedge clk); sck_i = 1'b1;
            repeat (HALF) @(negedge clk); sck_i = 1'b0;
        end
        select(1'b0);
        repeat (8) @(negedge clk);
        check("R9 no rxc on abort", flag_rxc, 0);
        check("R9 no txc on abort", flag_txc, 0);
        select(1'b1);
        xfer(8'h3C, got);
        select(1'b0);
        check("R9 realigned rx", rx_data, 8'h3C);
        check("R9 rxc after full byte", flag_rxc, 1);
        clear_flags();

        // Dummy-first start
        do_reset(1'b0);
        host_write(8'h43);
        repeat (4) @(negedge clk);
        check("R3 stays buffered", flag_dre, 0);
        host_write(8'h99);
        select(1'b1);
        xfer(8'hC3, got);
        check("R3 dummy byte", got, 8'h00);
        check("R6 dre rose at end", t_dre >= 0, 1);
        check("R7 rxc one after dre", t_rxc - t_dre, 1);
        check("R8 txc held pending", flag_txc, 0);
        clear_flags();
        host_write(8'h44);
        check("R6 dre cleared", flag_dre, 0);
        host_write(8'h45);
        xfer(8'h5A, got);
        check("R3 buffered byte next", got, 8'h43);
        check("R5 first write kept", got != 8'h99, 1);
        check("R8 txc held second", flag_txc, 0);
        clear_flags();
        xfer(8'hA5, got);
        select(1'b0);
        check("R5 dropped write lost", got, 8'h44);
        check("R7 rx_data", rx_data, 8'hA5);
        check("R8 txc one after rxc", t_txc - t_rxc, 1);
        check("R8 txc set", flag_txc, 1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule